// File: doc/BRIEF.md
# Three-Axis Sample Holding Buffer with Ready and Overrun Flags

This block sits between a magnetic measurement engine and a host-facing register file. Each time the engine raises a sample strobe, it delivers three signed axis values and a sensor overflow flag. The block clamps each axis to the legal 16-bit range and stores it. The host then reads the stored values as byte registers, low byte first. A status byte reports whether a fresh result is waiting and whether a result was lost before the host could read it.

In continuous operation a new result can arrive while the host is part-way through reading a set of bytes. To keep such a read from mixing two samples, the first read of a data byte locks the visible registers. The lock lasts until the host reads the closing status register at 18h. Samples that land during the lock are parked in a shadow copy, and only the newest one is kept. When the closing read happens, the parked sample becomes visible and is flagged as ready. If more than one sample was parked, it is also flagged as overrun. In single-shot operation there is no lock and no overrun.

Top module: `mag_sample_buffer`

## Requirements
- R1: After reset, status (10h) reads 00h, every byte at 11h..17h reads 00h, and the closing status at 18h reads 04h.
- R2: Each axis is clamped to the range -32752..+32752 and stored as two's complement. X sits at 11h (low byte) and 12h (high byte), Y at 13h/14h, and Z at 15h/16h. Register 17h always reads 00h.
- R3: A sample that becomes visible sets bit 0 of 10h (ready). Bits 7:2 of 10h always read 0.
- R4: A host read of any address from 11h to 18h clears both bits of 10h at the next clock. Reading 10h, or any address outside 10h..18h, changes nothing, and such an unused address reads 00h.
- R5: The closing status at 18h reads {4'b0000, ovf, 3'b100}. Here ovf is the sensor overflow flag of the sample currently visible.
- R6: In continuous mode, a sample that becomes visible while bit 0 of 10h is still set sets bit 1 (overrun).
- R7: In single mode, the visible registers never lock and bit 1 of 10h never sets. Each new sample replaces the visible one at once.
- R8: In continuous mode, a read of 11h..17h locks the visible data. The data stays unchanged until the cycle in which 18h is read.
- R9: A sample arriving under lock is kept in a shadow copy, newest wins. On the 18h read the copy becomes visible and bit 0 sets. Bit 1 sets only if two or more samples arrived under that lock.
- R10: A sample presented in the same cycle as the 18h read that releases a lock goes straight to the visible registers with bit 0 set. Any shadowed sample is discarded, and bit 1 sets only if one was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cont_mode | input | 1 | 1 selects continuous mode (locking and overrun enabled) |
| smp_valid | input | 1 | One-cycle strobe: new sample present |
| smp_x | input | IN_W | Raw signed X value |
| smp_y | input | IN_W | Raw signed Y value |
| smp_z | input | IN_W | Raw signed Z value |
| smp_ovf | input | 1 | Sensor overflow flag for this sample |
| rd_en | input | 1 | Host read strobe; side effects take place at the clock edge |
| rd_addr | input | 8 | Host register address |
| rd_data | output | 8 | Read data for rd_addr, combinational from the stored state |

## Verification
The bench uses the default raw width of 18 bits. These two bits beyond the stored 16 let it drive values far outside the legal range, as well as the values on each side of both clamp limits. A strided sweep over the whole 18-bit range is checked byte by byte against clamping computed in the bench. Directed sequences then drive lock, shadow, discard and same-cycle release orderings in both modes and compare the flags after each step.

// File: rtl/mag_sample_buffer_pkg.sv
// Package: register addresses and stored data width shared by the buffer.
// Assumes an 8-bit host address space; only the addresses below decode.
package mag_sample_buffer_pkg;
    localparam int          DATA_W = 16;
    localparam int          AXES   = 3;
    localparam logic [7:0]  A_STAT = 8'h10;   // ready / overrun byte
    localparam logic [7:0]  A_XL   = 8'h11;   // first data byte
    localparam logic [7:0]  A_PAD  = 8'h17;   // constant-zero data byte
    localparam logic [7:0]  A_END  = 8'h18;   // closing status, ends a lock
endpackage

// File: rtl/mag_sat.sv
// Module: clamps one signed raw axis value to +/-LIMIT and narrows it to
// OUT_W bits. Assumes IN_W >= OUT_W and LIMIT fits in OUT_W signed bits.
module mag_sat #(
    parameter int IN_W  = 18,
    parameter int OUT_W = 16,
    parameter int LIMIT = 32752
) (
    input  logic signed [IN_W-1:0] din,
    output logic [OUT_W-1:0]       dout
);
    localparam logic signed [IN_W-1:0] HI = IN_W'(LIMIT);
    localparam logic signed [IN_W-1:0] LO = IN_W'(-LIMIT);

    // pick the limit on overshoot, else pass the value through
    always_comb begin
        if (din > HI)      dout = HI[OUT_W-1:0];
        else if (din < LO) dout = LO[OUT_W-1:0];
        else               dout = din[OUT_W-1:0];
    end
endmodule

// File: rtl/mag_flags.sv
// Module: ready/overrun flags, the read lock and the shadow bookkeeping.
// Emits one-cycle load controls for the storage. Assumes host read side
// effects take place at the clock edge that ends the read cycle.
module mag_flags
    import mag_sample_buffer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cont_mode,
    input  logic       smp_valid,
    input  logic       rd_en,
    input  logic [7:0] rd_addr,
    output logic       drdy,
    output logic       dor,
    output logic       lock,
    output logic       vis_ld_smp,
    output logic       vis_ld_shd,
    output logic       shd_ld
);
    logic shv, skip;
    logic data_rd, st2_rd, clr, lock_n, rel;
    logic drdy_n, dor_n, shv_n, skip_n;

    // decode the host reads that carry side effects
    assign data_rd = rd_en && (rd_addr >= A_XL) && (rd_addr <= A_PAD);
    assign st2_rd  = rd_en && (rd_addr == A_END);
    assign clr     = data_rd || st2_rd;
    assign lock_n  = cont_mode && !st2_rd && (lock || data_rd);
    assign rel     = lock && !lock_n;

    // next-state: clear on read, commit shadow on release, then place sample
    always_comb begin
        drdy_n     = clr ? 1'b0 : drdy;
        dor_n      = clr ? 1'b0 : dor;
        shv_n      = shv;
        skip_n     = skip;
        vis_ld_smp = 1'b0;
        vis_ld_shd = 1'b0;
        shd_ld     = 1'b0;
        if (rel && shv) begin
            vis_ld_shd = 1'b1;
            drdy_n     = 1'b1;
            dor_n      = skip && cont_mode;
            shv_n      = 1'b0;
            skip_n     = 1'b0;
        end
        if (smp_valid) begin
            if (lock_n) begin
                shd_ld = 1'b1;
                skip_n = skip_n || shv_n;
                shv_n  = 1'b1;
            end else begin
                vis_ld_smp = 1'b1;
                dor_n      = dor_n || (drdy_n && cont_mode);
                drdy_n     = 1'b1;
            end
        end
    end

    // state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drdy <= 1'b0;
            dor  <= 1'b0;
            lock <= 1'b0;
            shv  <= 1'b0;
            skip <= 1'b0;
        end else begin
            drdy <= drdy_n;
            dor  <= dor_n;
            lock <= lock_n;
            shv  <= shv_n;
            skip <= skip_n;
        end
    end

    a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr >= A_XL && rd_addr <= A_END && !smp_valid && !(lock && shv))
        |=> (!drdy && !dor));
    a_r7_no_overrun_single: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dor) |-> $past(cont_mode));
    a_r7_no_lock_single: assert property (@(posedge clk) disable iff (!rst_n)
        !cont_mode |=> !lock);
    a_r9_shadow_held: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && lock && cont_mode && !(rd_en && rd_addr == A_END)) |=> shv);
    a_r3_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !cont_mode) |=> drdy);
endmodule

// File: rtl/mag_store.sv
// Module: visible and shadow sample registers plus the host read mux.
// Assumes at most one of the load controls selects the visible copy per
// cycle, except that a fresh sample overrides a shadow commit.
module mag_store
    import mag_sample_buffer_pkg::*;
#(
    parameter int LIMIT = 32752
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [AXES-1:0][DATA_W-1:0] smp_d,
    input  logic                       smp_ovf,
    input  logic                       vis_ld_smp,
    input  logic                       vis_ld_shd,
    input  logic                       shd_ld,
    input  logic                       lock,
    input  logic                       drdy,
    input  logic                       dor,
    input  logic [7:0]                 rd_addr,
    output logic [7:0]                 rd_data
);
    logic [AXES-1:0][DATA_W-1:0] vis_q, shd_q;
    logic                        vis_ovf, shd_ovf;
    logic [7:0]                  off;

    // visible registers: fresh sample wins over shadow commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vis_q   <= '0;
            vis_ovf <= 1'b0;
        end else if (vis_ld_smp) begin
            vis_q   <= smp_d;
            vis_ovf <= smp_ovf;
        end else if (vis_ld_shd) begin
            vis_q   <= shd_q;
            vis_ovf <= shd_ovf;
        end
    end

    // shadow registers: newest sample under lock overwrites
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shd_q   <= '0;
            shd_ovf <= 1'b0;
        end else if (shd_ld) begin
            shd_q   <= smp_d;
            shd_ovf <= smp_ovf;
        end
    end

    // host read mux over the byte address map
    assign off = rd_addr - A_XL;
    always_comb begin
        rd_data = 8'h00;
        if (rd_addr == A_STAT)
            rd_data = {6'b0, dor, drdy};
        else if (rd_addr >= A_XL && rd_addr < A_PAD)
            rd_data = off[0] ? vis_q[off[2:1]][15:8] : vis_q[off[2:1]][7:0];
        else if (rd_addr == A_END)
            rd_data = {4'b0000, vis_ovf, 3'b100};
    end

    a_r8_locked_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && $past(lock)) |-> ($stable(vis_q) && $stable(vis_ovf)));

    for (genvar i = 0; i < AXES; i++) begin : g_rng
        a_r2_in_range: assert property (@(posedge clk) disable iff (!rst_n)
            ($signed(vis_q[i]) <= LIMIT) && ($signed(vis_q[i]) >= -LIMIT));
    end
endmodule

// File: rtl/mag_sample_buffer.sv
// Module: top of the three-axis sample buffer. Clamps raw axis values,
// tracks ready/overrun/lock and serves byte reads. Assumes smp_valid is
// a single-cycle strobe and rd_data is sampled before the read edge.
module mag_sample_buffer
    import mag_sample_buffer_pkg::*;
#(
    parameter int IN_W  = 18,
    parameter int LIMIT = 32752
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cont_mode,
    input  logic                   smp_valid,
    input  logic signed [IN_W-1:0] smp_x,
    input  logic signed [IN_W-1:0] smp_y,
    input  logic signed [IN_W-1:0] smp_z,
    input  logic                   smp_ovf,
    input  logic                   rd_en,
    input  logic [7:0]             rd_addr,
    output logic [7:0]             rd_data
);
    logic [AXES-1:0][IN_W-1:0]   raw;
    logic [AXES-1:0][DATA_W-1:0] clamped;
    logic drdy, dor, lock, vis_ld_smp, vis_ld_shd, shd_ld;

    assign raw = {smp_z, smp_y, smp_x};

    for (genvar i = 0; i < AXES; i++) begin : g_sat
        mag_sat #(.IN_W(IN_W), .OUT_W(DATA_W), .LIMIT(LIMIT)) u_sat (
            .din  ($signed(raw[i])),
            .dout (clamped[i])
        );
    end

    mag_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .cont_mode  (cont_mode),
        .smp_valid  (smp_valid),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .drdy       (drdy),
        .dor        (dor),
        .lock       (lock),
        .vis_ld_smp (vis_ld_smp),
        .vis_ld_shd (vis_ld_shd),
        .shd_ld     (shd_ld)
    );

    mag_store #(.LIMIT(LIMIT)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_d      (clamped),
        .smp_ovf    (smp_ovf),
        .vis_ld_smp (vis_ld_smp),
        .vis_ld_shd (vis_ld_shd),
        .shd_ld     (shd_ld),
        .lock       (lock),
        .drdy       (drdy),
        .dor        (dor),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data)
    );
endmodule

// File: tb/mag_sample_buffer_test.sv
`timescale 1ns/1ps
module mag_sample_buffer_test;
    localparam int IN_W = 18;
    localparam int LIM  = 32752;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cont_mode = 1'b0, smp_valid = 1'b0, smp_ovf = 1'b0, rd_en = 1'b0;
    logic signed [IN_W-1:0] smp_x = '0, smp_y = '0, smp_z = '0;
    logic [7:0] rd_addr = 8'h00;
    logic [7:0] rd_data;
    int n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;

    mag_sample_buffer #(.IN_W(IN_W), .LIMIT(LIM)) uut (.*);

    function automatic int sat(input int v);
        return (v > LIM) ? LIM : ((v < -LIM) ? -LIM : v);
    endfunction

    task automatic chk(input int act, input int exp, input string req);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    // one cycle: optional sample and optional read; d = read data before the edge
    task automatic cyc(input bit sv, input int x, input int y, input int z,
                       input bit ovf, input bit re, input logic [7:0] a,
                       output logic [7:0] d);
        @(negedge clk);
        smp_valid = sv; smp_x = IN_W'(x); smp_y = IN_W'(y); smp_z = IN_W'(z);
        smp_ovf = ovf; rd_en = re; rd_addr = a;
        #1 d = rd_data;
        @(posedge clk);
        #1 smp_valid = 1'b0; rd_en = 1'b0; smp_ovf = 1'b0;
    endtask

    task automatic smp(input int x, input int y, input int z, input bit ovf);
        logic [7:0] d;
        cyc(1'b1, x, y, z, ovf, 1'b0, 8'h00, d);
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        cyc(1'b0, 0, 0, 0, 1'b0, 1'b1, a, d);
    endtask

    task automatic chk_rd(input logic [7:0] a, input int exp, input string req);
        logic [7:0] d;
        rd(a, d);
        chk(d, exp, req);
    endtask

    // watchdog: a hung run counts as a failed check
    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int vals[11] = '{-131072, -32753, -32752, -32751, -1, 0, 1, 32751, 32752, 32753, 131071};
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset values
        chk_rd(8'h10, 8'h00, "R1 status");
        for (int a = 8'h11; a <= 8'h17; a++) chk_rd(8'(a), 8'h00, "R1 data");
        chk_rd(8'h18, 8'h04, "R1 closing status");

        // R2/R3/R4: single-mode sweep over raw codes, clamping and byte order
        for (int k = 0; k < 268; k++) begin
            int v  = (k < 11) ? vals[k] : (-131072 + (k - 11) * 1021);
            int ex = sat(v), ey = sat(~v), ez = sat(v >>> 3);
            smp(v, ~v, v >>> 3, 1'b0);
            chk_rd(8'h10, 8'h01, "R3 ready after sample");
            chk_rd(8'h11, ex & 8'hFF, "R2 X low");
            chk_rd(8'h10, 8'h00, "R4 cleared by data read");
            chk_rd(8'h12, (ex >> 8) & 8'hFF, "R2 X high");
            chk_rd(8'h13, ey & 8'hFF, "R2 Y low");
            chk_rd(8'h14, (ey >> 8) & 8'hFF, "R2 Y high");
            chk_rd(8'h15, ez & 8'hFF, "R2 Z low");
            chk_rd(8'h16, (ez >> 8) & 8'hFF, "R2 Z high");
            chk_rd(8'h17, 8'h00, "R2 pad byte");
        end

        // R5: overflow flag follows the visible sample
        smp(10, 20, 30, 1'b1);
        chk_rd(8'h18, 8'h0C, "R5 ovf set");
        smp(10, 20, 30, 1'b0);
        chk_rd(8'h18, 8'h04, "R5 ovf clear");

        // R4: unmapped and status reads have no side effect
        smp(1, 2, 3, 1'b0);
        chk_rd(8'h20, 8'h00, "R4 unused address");
        chk_rd(8'h10, 8'h01, "R4 status read 1");
        chk_rd(8'h10, 8'h01, "R4 status read 2");
        chk_rd(8'h17, 8'h00, "R4 pad read");
        chk_rd(8'h10, 8'h00, "R4 pad read clears");

        // R7: single mode, no lock, no overrun
        smp(100, 0, 0, 1'b0);
        chk_rd(8'h11, 100, "R7 first low");
        smp(4660, 0, 0, 1'b0);
        chk_rd(8'h12, 8'h12, "R7 new data visible at once");
        smp(22136, 0, 0, 1'b0);
        chk_rd(8'h10, 8'h01, "R7 no overrun in single");
        chk_rd(8'h18, 8'h04, "R7 clear");

        // R6: continuous, unread sample replaced
        @(negedge clk) cont_mode = 1'b1;
        smp(100, 200, 300, 1'b0);
        smp(-5, 6, 7, 1'b0);
        chk_rd(8'h10, 8'h03, "R6 overrun set");
        chk_rd(8'h11, 8'hFB, "R6 newest visible");
        chk_rd(8'h18, 8'h04, "R6 release");
        chk_rd(8'h10, 8'h00, "R6 flags cleared");

        // R8/R9: protected read with one sample under lock
        smp(4097, 0, 0, 1'b0);
        chk_rd(8'h11, 8'h01, "R8 C low");
        smp(8738, 0, 0, 1'b1);
        chk_rd(8'h12, 8'h10, "R8 C high held");
        chk_rd(8'h10, 8'h00, "R9 shadow not shown");
        chk_rd(8'h18, 8'h04, "R8 ovf of held sample");
        chk_rd(8'h10, 8'h01, "R9 commit ready no overrun");
        chk_rd(8'h12, 8'h22, "R9 committed high");
        chk_rd(8'h18, 8'h0C, "R9 committed ovf");

        // R9: two samples under lock, newest wins with overrun
        smp(1, 1, 1, 1'b0);
        chk_rd(8'h13, 8'h01, "R9 lock start");
        smp(2, 2, 2, 1'b0);
        smp(3, 3, 3, 1'b0);
        chk_rd(8'h15, 8'h01, "R8 Z still old");
        chk_rd(8'h18, 8'h04, "R9 release");
        chk_rd(8'h10, 8'h03, "R9 overrun after two");
        chk_rd(8'h11, 8'h03, "R9 newest wins");
        chk_rd(8'h18, 8'h04, "R9 unlock");

        // R10: sample in release cycle with a shadowed sample
        smp(40, 0, 0, 1'b0);
        chk_rd(8'h11, 40, "R10 lock start");
        smp(41, 0, 0, 1'b0);
        cyc(1'b1, 42, 0, 0, 1'b0, 1'b1, 8'h18, d);
        chk(d, 8'h04, "R10 closing read");
        chk_rd(8'h10, 8'h03, "R10 discard flagged");
        chk_rd(8'h11, 42, "R10 fresh sample visible");
        chk_rd(8'h18, 8'h04, "R10 unlock");

        // R10: sample in release cycle without shadow
        smp(50, 0, 0, 1'b0);
        chk_rd(8'h11, 50, "R10 lock start 2");
        cyc(1'b1, 51, 0, 0, 1'b0, 1'b1, 8'h18, d);
        chk_rd(8'h10, 8'h01, "R10 ready only");
        chk_rd(8'h11, 51, "R10 fresh visible 2");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule